// File: doc/BRIEF.md
# Timer Edge Capture Unit

This block watches an asynchronous event pin and, when a selected transition arrives, stores the current value of a free-running timer count. The pin is synchronized first. A two-bit transition selector picks which changes count as an event: none, rising, falling or both. A separate mode input picks between two behaviours. In the first, one event captures one timestamp. In the second, two events capture a pair of timestamps, which is useful for measuring a period or a pulse width.

When a capture completes, a sticky flag is raised for the interrupt logic. Software clears it with a one-cycle write-one-to-clear strobe. While the flag is up, the stored timestamps are frozen. Moving the transition selector from zero to any active value re-arms the unit. Re-arming drops the flag and discards any half-finished two-event capture. The counter, the register decoder and interrupt merging all sit outside this block.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset both capture registers read 0 and the flag reads 0.
- R2: With the transition selector at 0 (none), pin changes capture nothing and leave the flag unchanged.
- R3: Selector value 1 qualifies only low-to-high pin transitions; a high-to-low transition is ignored.
- R4: Selector value 2 qualifies only high-to-low pin transitions; a low-to-high transition is ignored.
- R5: Selector value 3 qualifies transitions in both directions.
- R6: With the mode input at 0 (single), the first qualifying event loads capture register 1 and sets the flag. Capture register 2 keeps its value.
- R7: With the mode input at 1 (second event), the first qualifying event loads capture register 1 and leaves the flag clear. The next qualifying event loads capture register 2 and sets the flag.
- R8: While the flag is set and no clear strobe is present, qualifying events change neither capture register.
- R9: A clear strobe with no concurrent capture drops the flag on the next clock.
- R10: If a clear strobe and a completing capture fall on the same clock, the capture is taken and the flag stays set.
- R11: A change of the selector from 0 to a nonzero value clears the flag and any pending first event of a two-event capture.
- R12: A pin change applied before clock edge k is captured with the count value presented at edge k+2. This delay comes from two synchronizer stages and one detection stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| evt_pin | input | 1 | Asynchronous event input |
| count_in | input | CNT_W | Current value of the free-running timer |
| edge_sel | input | 2 | Transition selector: 0 none, 1 rising, 2 falling, 3 both |
| pair_mode | input | 1 | 0 single capture, 1 capture on second event |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cap1_q | output | CNT_W | First capture register |
| cap2_q | output | CNT_W | Second capture register |
| cap_flag | output | 1 | Capture complete flag |

## Verification
The bench targets the re-arm path. A design that forgot to drop the pending first event would report the second timestamp of a stale pair after re-arming. One that cleared the flag on any selector change would lose an interrupt when the selector returns to zero.

The bench lands a clear strobe on the very clock of a completing capture. A design that let the clear win would drop that event silently. It also sends events while the flag is held; a design that kept capturing would overwrite timestamps software has not yet read.

Finally, a count that changes every cycle pins down the exact sampling edge. An extra or missing pipeline stage would store a neighbouring value.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/ecu_edge_det.sv
module ecu_edge_det
  import ecu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  edge_sel_e sel,
  input  logic      arm,
  output logic      hit
);
  logic prev_q;
  logic rise, fall, raw;

  // Previous sample always follows the level; on re-arm it therefore
  // reloads the present level, so no stale edge survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    unique case (sel)
      EDGE_RISE: raw = rise;
      EDGE_FALL: raw = fall;
      EDGE_BOTH: raw = rise | fall;
      default:   raw = 1'b0;
    endcase
    hit = raw & ~arm;
  end

  assert_idle_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_NONE) |-> !hit);
  assert_arm_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> !hit);
  assert_rise_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_RISE && hit) |=> prev_q);
  assert_fall_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_FALL && hit) |=> !prev_q);
endmodule

// File: rtl/ecu_capture_ctrl.sv
module ecu_capture_ctrl #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             pair_mode,
  input  logic             flag_clr,
  input  logic             arm,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap1,
  output logic [CNT_W-1:0] cap2,
  output logic             flag
);
  logic [CNT_W-1:0] cap1_q, cap2_q;
  logic flag_q, flag_d;
  logic first_q, first_d;
  logic cap1_en, cap2_en, accept;

  always_comb begin
    accept  = hit & (~flag_q | flag_clr);
    flag_d  = flag_q;
    first_d = first_q;
    cap1_en = 1'b0;
    cap2_en = 1'b0;
    if (arm) begin
      flag_d  = 1'b0;
      first_d = 1'b0;
    end else begin
      if (flag_clr) flag_d = 1'b0;
      if (accept) begin
        if (!pair_mode) begin
          cap1_en = 1'b1;
          flag_d  = 1'b1;
          first_d = 1'b0;
        end else if (!first_q) begin
          cap1_en = 1'b1;
          first_d = 1'b1;
        end else begin
          cap2_en = 1'b1;
          flag_d  = 1'b1;
          first_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap1_q  <= '0;
      cap2_q  <= '0;
      flag_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (cap1_en) cap1_q <= count;
      if (cap2_en) cap2_q <= count;
      flag_q  <= flag_d;
      first_q <= first_d;
    end
  end

  assign cap1 = cap1_q;
  assign cap2 = cap2_q;
  assign flag = flag_q;

  assert_hold_caps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> ($stable(cap1_q) && $stable(cap2_q)));
  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && flag_clr && !hit) |=> !flag_q);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && flag_clr && !pair_mode && !arm) |=> flag_q);
  assert_first_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pair_mode && !first_q && !flag_q && !arm) |=> (!flag_q && first_q));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pin,
  input  logic [CNT_W-1:0] count_in,
  input  logic [1:0]       edge_sel,
  input  logic             pair_mode,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap1_q,
  output logic [CNT_W-1:0] cap2_q,
  output logic             cap_flag
);
  localparam int RST_STAGES = 2;

  logic      rst_sync_n;
  logic      evt_s;
  logic      arm, hit;
  edge_sel_e sel, sel_prev_q;

  ecu_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  ecu_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(evt_pin), .q(evt_s)
  );

  assign sel = edge_sel_e'(edge_sel);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sel_prev_q <= EDGE_NONE;
    else             sel_prev_q <= sel;
  end

  assign arm = (sel_prev_q == EDGE_NONE) && (sel != EDGE_NONE);

  ecu_edge_det u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl(evt_s), .sel(sel), .arm(arm), .hit(hit)
  );

  ecu_capture_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .hit(hit), .pair_mode(pair_mode),
    .flag_clr(flag_clr), .arm(arm), .count(count_in),
    .cap1(cap1_q), .cap2(cap2_q), .flag(cap_flag)
  );

  assert_rearm_clears_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arm |=> !cap_flag);
  assert_idle_keeps_flag_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cap_flag && !flag_clr && sel == EDGE_NONE) |=> cap_flag);
endmodule

// File: tb/edge_capture_unit_bench.sv
module edge_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_pin;
  logic [31:0] count_in;
  logic [1:0]  edge_sel;
  logic        pair_mode;
  logic        flag_clr;
  logic [31:0] cap1_q, cap2_q;
  logic        cap_flag;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  edge_capture_unit u_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .count_in(count_in),
    .edge_sel(edge_sel), .pair_mode(pair_mode), .flag_clr(flag_clr),
    .cap1_q(cap1_q), .cap2_q(cap2_q), .cap_flag(cap_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input logic v, input logic [31:0] c);
    @(negedge clk);
    count_in = c;
    evt_pin  = v;
    wait_n(4);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    wait_n(1);
  endtask

  task automatic t_reset();
    check("R1 cap1", cap1_q, 0);
    check("R1 cap2", cap2_q, 0);
    check("R1 flag", {31'd0, cap_flag}, 0);
  endtask

  task automatic t_idle();
    edge_sel = 2'd0;
    set_pin(1'b1, 32'd11);
    set_pin(1'b0, 32'd12);
    check("R2 flag", {31'd0, cap_flag}, 0);
    check("R2 cap1", cap1_q, 0);
  endtask

  task automatic t_rise();
    pair_mode = 1'b0;
    @(negedge clk); edge_sel = 2'd1; wait_n(2);
    set_pin(1'b1, 32'd20);
    check("R6 cap1", cap1_q, 20);
    check("R6 flag", {31'd0, cap_flag}, 1);
    check("R6 cap2", cap2_q, 0);
    set_pin(1'b0, 32'd21);
    set_pin(1'b1, 32'd21);
    check("R8 cap1 held", cap1_q, 20);
    clear_flag();
    check("R9 flag", {31'd0, cap_flag}, 0);
    set_pin(1'b0, 32'd22);
    check("R3 fall ignored flag", {31'd0, cap_flag}, 0);
    check("R3 fall ignored cap1", cap1_q, 20);
  endtask

  task automatic t_fall();
    @(negedge clk); edge_sel = 2'd2; wait_n(2);
    set_pin(1'b1, 32'd30);
    check("R4 rise ignored", {31'd0, cap_flag}, 0);
    set_pin(1'b0, 32'd31);
    check("R4 cap1", cap1_q, 31);
    check("R4 flag", {31'd0, cap_flag}, 1);
    clear_flag();
  endtask

  task automatic t_both();
    @(negedge clk); edge_sel = 2'd3; wait_n(2);
    set_pin(1'b1, 32'd40);
    check("R5 rise cap1", cap1_q, 40);
    clear_flag();
    set_pin(1'b0, 32'd41);
    check("R5 fall cap1", cap1_q, 41);
    check("R5 flag", {31'd0, cap_flag}, 1);
    clear_flag();
  endtask

  task automatic t_pair();
    @(negedge clk); pair_mode = 1'b1;
    set_pin(1'b1, 32'd50);
    check("R7 first cap1", cap1_q, 50);
    check("R7 first no flag", {31'd0, cap_flag}, 0);
    set_pin(1'b0, 32'd51);
    check("R7 second cap2", cap2_q, 51);
    check("R7 second flag", {31'd0, cap_flag}, 1);
    check("R7 cap1 kept", cap1_q, 50);
    clear_flag();
  endtask

  task automatic t_set_wins();
    @(negedge clk); pair_mode = 1'b0;
    set_pin(1'b1, 32'd60);
    check("R10 pre flag", {31'd0, cap_flag}, 1);
    @(negedge clk); evt_pin = 1'b0; count_in = 32'd61;
    @(negedge clk);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check("R10 flag kept", {31'd0, cap_flag}, 1);
    check("R10 cap1", cap1_q, 61);
    clear_flag();
  endtask

  task automatic t_rearm();
    @(negedge clk); pair_mode = 1'b1; edge_sel = 2'd1; wait_n(2);
    set_pin(1'b1, 32'd70);
    check("R11 pending cap1", cap1_q, 70);
    @(negedge clk); edge_sel = 2'd0; wait_n(2);
    @(negedge clk); edge_sel = 2'd1; wait_n(2);
    set_pin(1'b0, 32'd71);
    set_pin(1'b1, 32'd71);
    check("R11 restart cap1", cap1_q, 71);
    check("R11 restart no flag", {31'd0, cap_flag}, 0);
    set_pin(1'b0, 32'd72);
    set_pin(1'b1, 32'd72);
    check("R11 pair cap2", cap2_q, 72);
    check("R11 pair flag", {31'd0, cap_flag}, 1);
    @(negedge clk); edge_sel = 2'd0; wait_n(2);
    check("R2 flag kept at idle", {31'd0, cap_flag}, 1);
    @(negedge clk); edge_sel = 2'd2;
    @(negedge clk);
    check("R11 flag cleared", {31'd0, cap_flag}, 0);
  endtask

  task automatic t_latency();
    @(negedge clk); pair_mode = 1'b0; edge_sel = 2'd1; wait_n(2);
    set_pin(1'b0, 32'd90);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      count_in = 32'd100 + 32'(i);
      if (i == 0) evt_pin = 1'b1;
    end
    check("R12 cap1 sampled count", cap1_q, 102);
    check("R12 flag", {31'd0, cap_flag}, 1);
  endtask

  initial begin
    rst_n = 1'b0; evt_pin = 1'b0; count_in = '0;
    edge_sel = 2'd0; pair_mode = 1'b0; flag_clr = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_idle();
    t_rise();
    t_fall();
    t_both();
    t_pair();
    t_set_wins();
    t_rearm();
    t_latency();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule